// File: doc/BRIEF.md
# Host/Device Word Mailbox

This block passes 32-bit words in both directions between a debug host port and a device CPU port. The outbound box carries words from host to device and the inbound box carries words from device to host. Each box has one data word and one full/empty bit. Accesses to a data register change that bit as a side effect: a write fills the box and a read by the consuming side empties it. The full/empty bit of each box is also brought out as a pin, so either side can raise an interrupt from it.

Each direction also has a 7-bit flag field for software. Only the sending side of that direction can write it. Two peek registers let either side read both data words without changing any status. Both ports are simple synchronous register ports in one clock domain. Read data is combinational from the current register state, so a read returns the word stored before any write in the same cycle.

Top module: `hd_mailbox`

## Requirements
- R1: After reset, both data words, both flag fields and both full bits are 0, and `tx_full_o` and `rx_full_o` are low.
- R2: A host write to offset 0x100 stores the word and sets the outbound full bit. A write while the box is already full replaces the word, and the bit stays 1.
- R3: A device read of offset 0x100 clears the outbound full bit. A host read of 0x100 leaves the bit unchanged. A read while the box is empty returns the stored word.
- R4: If the host writes 0x100 in the same cycle that the device reads it, the device sees the previous word, the new word is stored and the outbound full bit ends at 1.
- R5: A device write to 0x108 stores the word and sets the inbound full bit. A host read of 0x108 clears the bit, and so does a device read of 0x108 (flush).
- R6: If the device writes 0x108 in the same cycle that the host reads it, the host sees the previous word, the new word is stored and the inbound full bit ends at 1.
- R7: The control registers are at 0x104 (outbound) and 0x10C (inbound). In each one, bit 0 is the full bit, bits 7:1 are the flags and bits 31:8 read as 0. The host writes the outbound flags from write-data bits 7:1, and the device writes the inbound flags from write-data bits 7:1.
- R8: From either port, 0x110 returns the outbound word and 0x114 returns the inbound word. Reading them never changes a full bit.
- R9: Writes that a side is not allowed to make have no effect. These are device writes to 0x100 and 0x104, host writes to 0x108 and 0x10C, writes from either side to 0x110 and 0x114, and write-data bit 0 of a control-register write, which leaves the full bit unchanged.
- R10: `tx_full_o` always equals the outbound full bit and `rx_full_o` always equals the inbound full bit. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 12 | Host byte offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects only) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| d_addr | input | 12 | Device byte offset |
| d_wr | input | 1 | Device write strobe |
| d_rd | input | 1 | Device read strobe (side effects only) |
| d_wdata | input | 32 | Device write data |
| d_rdata | output | 32 | Device read data for d_addr |
| tx_full_o | output | 1 | Outbound box full, to device |
| rx_full_o | output | 1 | Inbound box full, to host |

## Verification
Directed sequences first step through each box's fill, overwrite, drain and flush. Next they apply the two same-cycle collisions, which show whether a read returns the old word and whether set takes priority over clear. Forbidden writes and peeks follow, each with a readback at the ports that would reveal any change they made. A long seeded random run then drives both ports at once over every mapped offset plus one unmapped offset. This uncovers interactions between the two sides that the directed cases never combine, such as a host read of inbound data in the same cycle as a device flag write.

// File: rtl/hd_mailbox.sv
module hd_mailbox #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_wr,
  input  logic              d_rd,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] d_rdata,
  output logic              tx_full_o,
  output logic              rx_full_o
);
  localparam logic [ADDR_W-1:0] OFS_TXD  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] OFS_TXC  = ADDR_W'(12'h104);
  localparam logic [ADDR_W-1:0] OFS_RXD  = ADDR_W'(12'h108);
  localparam logic [ADDR_W-1:0] OFS_RXC  = ADDR_W'(12'h10C);
  localparam logic [ADDR_W-1:0] OFS_TXPK = ADDR_W'(12'h110);
  localparam logic [ADDR_W-1:0] OFS_RXPK = ADDR_W'(12'h114);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [FLAG_W-1:0] txfl_q, rxfl_q;
  logic              txf_q, rxf_q;

  wire h_txd_wr = h_wr && (h_addr == OFS_TXD);
  wire h_txc_wr = h_wr && (h_addr == OFS_TXC);
  wire h_rxd_rd = h_rd && (h_addr == OFS_RXD);
  wire d_txd_rd = d_rd && (d_addr == OFS_TXD);
  wire d_rxd_wr = d_wr && (d_addr == OFS_RXD);
  wire d_rxc_wr = d_wr && (d_addr == OFS_RXC);
  wire d_rxd_rd = d_rd && (d_addr == OFS_RXD);

  wire [DATA_W-1:0] tx_ctl = DATA_W'({txfl_q, txf_q});
  wire [DATA_W-1:0] rx_ctl = DATA_W'({rxfl_q, rxf_q});

  function automatic logic [DATA_W-1:0] rd_mux(input logic [ADDR_W-1:0] a,
      input logic [DATA_W-1:0] t, input logic [DATA_W-1:0] tc,
      input logic [DATA_W-1:0] r, input logic [DATA_W-1:0] rc);
    case (a)
      OFS_TXD, OFS_TXPK: rd_mux = t;
      OFS_TXC:           rd_mux = tc;
      OFS_RXD, OFS_RXPK: rd_mux = r;
      OFS_RXC:           rd_mux = rc;
      default:           rd_mux = '0;
    endcase
  endfunction

  assign h_rdata   = rd_mux(h_addr, tx_q, tx_ctl, rx_q, rx_ctl);
  assign d_rdata   = rd_mux(d_addr, tx_q, tx_ctl, rx_q, rx_ctl);
  assign tx_full_o = txf_q;
  assign rx_full_o = rxf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      txfl_q <= '0;
      txf_q  <= 1'b0;
    end else begin
      if (h_txd_wr) tx_q <= h_wdata;
      if (h_txc_wr) txfl_q <= h_wdata[FLAG_W:1];
      if (h_txd_wr)      txf_q <= 1'b1;
      else if (d_txd_rd) txf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q   <= '0;
      rxfl_q <= '0;
      rxf_q  <= 1'b0;
    end else begin
      if (d_rxd_wr) rx_q <= d_wdata;
      if (d_rxc_wr) rxfl_q <= d_wdata[FLAG_W:1];
      if (d_rxd_wr)                  rxf_q <= 1'b1;
      else if (h_rxd_rd || d_rxd_rd) rxf_q <= 1'b0;
    end
  end

  a_r2_host_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == OFS_TXD) |=> (tx_full_o && tx_q == $past(h_wdata)));

  a_r3_host_read_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_wr && h_addr == OFS_TXD && !(d_rd && d_addr == OFS_TXD)) |=> $stable(tx_full_o));

  a_r4_tx_collision_full: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == OFS_TXD && d_rd && d_addr == OFS_TXD) |=> tx_full_o);

  a_r5_dev_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && d_addr == OFS_RXD) |=> (rx_full_o && rx_q == $past(d_wdata)));

  a_r6_rx_collision_full: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && d_addr == OFS_RXD && h_rd && h_addr == OFS_RXD) |=> rx_full_o);

  a_r8_peek_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_wr && !d_wr && !d_rd && (h_addr == OFS_TXPK || h_addr == OFS_RXPK))
      |=> ($stable(tx_full_o) && $stable(rx_full_o)));

  a_r9_dev_txd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && d_addr == OFS_TXD && !h_wr) |=> $stable(tx_q));

  a_r9_host_rxd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == OFS_RXD && !d_wr) |=> $stable(rx_q));
endmodule

// File: tb/hd_mailbox_tb.sv
`timescale 1ns/1ps
module hd_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] h_addr = '0, d_addr = '0;
  logic        h_wr = 0, h_rd = 0, d_wr = 0, d_rd = 0;
  logic [31:0] h_wdata = '0, d_wdata = '0;
  logic [31:0] h_rdata, d_rdata;
  logic        tx_full_o, rx_full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_tx = '0, m_rx = '0;
  logic [6:0]  m_txfl = '0, m_rxfl = '0;
  logic        m_txf = 0, m_rxf = 0;

  hd_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_addr(d_addr), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .tx_full_o(tx_full_o), .rx_full_o(rx_full_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h100, 12'h110: return m_tx;
      12'h104:          return {24'h0, m_txfl, m_txf};
      12'h108, 12'h114: return m_rx;
      12'h10C:          return {24'h0, m_rxfl, m_rxf};
      default:          return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag,
      input logic hw, input logic hr, input logic [11:0] ha, input logic [31:0] hd,
      input logic dw, input logic dr, input logic [11:0] da, input logic [31:0] dd);
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    d_wr = dw; d_rd = dr; d_addr = da; d_wdata = dd;
    #1;
    chk(tag, "host rdata", h_rdata, exp_rd(ha));
    chk(tag, "dev rdata", d_rdata, exp_rd(da));
    chk("R10", "tx_full_o", {31'h0, tx_full_o}, {31'h0, m_txf});
    chk("R10", "rx_full_o", {31'h0, rx_full_o}, {31'h0, m_rxf});
    @(posedge clk);
    if (rst_n) begin
      if (hw && ha == 12'h100) m_tx = hd;
      if (hw && ha == 12'h104) m_txfl = hd[7:1];
      if (hw && ha == 12'h100) m_txf = 1'b1;
      else if (dr && da == 12'h100) m_txf = 1'b0;
      if (dw && da == 12'h108) m_rx = dd;
      if (dw && da == 12'h10C) m_rxfl = dd[7:1];
      if (dw && da == 12'h108) m_rxf = 1'b1;
      else if ((hr && ha == 12'h108) || (dr && da == 12'h108)) m_rxf = 1'b0;
    end
  endtask

  task automatic look(input string tag, input logic [11:0] ha, input logic [11:0] da);
    cyc(tag, 0, 0, ha, 32'h0, 0, 0, da, 32'h0);
  endtask

  function automatic logic [11:0] pick_addr();
    case ($urandom_range(0, 6))
      0: return 12'h100;
      1: return 12'h104;
      2: return 12'h108;
      3: return 12'h10C;
      4: return 12'h110;
      5: return 12'h114;
      default: return 12'h118;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0;
    cyc("R1", 1, 0, 12'h100, 32'hDEAD_BEEF, 1, 0, 12'h108, 32'hCAFE_F00D);
    cyc("R1", 0, 0, 12'h100, 32'h0, 0, 0, 12'h108, 32'h0);
    rst_n = 1;
    look("R1", 12'h104, 12'h10C);
    look("R1", 12'h110, 12'h114);

    cyc("R2", 1, 0, 12'h100, 32'h1111_0001, 0, 0, 12'h000, 0);
    look("R2", 12'h100, 12'h104);
    cyc("R2", 1, 0, 12'h100, 32'h2222_0002, 0, 0, 12'h000, 0);
    look("R2", 12'h104, 12'h100);

    cyc("R3", 0, 1, 12'h100, 0, 0, 0, 12'h000, 0);
    look("R3", 12'h104, 12'h104);
    cyc("R3", 0, 0, 12'h000, 0, 0, 1, 12'h100, 0);
    look("R3", 12'h104, 12'h104);
    cyc("R3", 0, 0, 12'h000, 0, 0, 1, 12'h100, 0);
    look("R3", 12'h104, 12'h100);

    cyc("R4", 1, 0, 12'h100, 32'h3333_0003, 0, 1, 12'h100, 0);
    look("R4", 12'h104, 12'h100);

    cyc("R5", 0, 0, 12'h000, 0, 1, 0, 12'h108, 32'h4444_0004);
    look("R5", 12'h10C, 12'h108);
    cyc("R5", 0, 1, 12'h108, 0, 0, 0, 12'h000, 0);
    look("R5", 12'h10C, 12'h10C);
    cyc("R5", 0, 0, 12'h000, 0, 1, 0, 12'h108, 32'h5555_0005);
    cyc("R5", 0, 0, 12'h000, 0, 0, 1, 12'h108, 0);
    look("R5", 12'h10C, 12'h108);

    cyc("R6", 0, 1, 12'h108, 0, 1, 0, 12'h108, 32'h6666_0006);
    look("R6", 12'h108, 12'h10C);

    cyc("R7", 1, 0, 12'h104, 32'hFFFF_FFFE, 0, 0, 12'h000, 0);
    cyc("R7", 0, 0, 12'h000, 0, 1, 0, 12'h10C, 32'h0000_00A4);
    look("R7", 12'h104, 12'h10C);

    cyc("R9", 0, 0, 12'h000, 0, 1, 0, 12'h100, 32'hBAD0_0001);
    cyc("R9", 0, 0, 12'h000, 0, 1, 0, 12'h104, 32'h0000_0000);
    cyc("R9", 1, 0, 12'h108, 32'hBAD0_0002, 0, 0, 12'h000, 0);
    cyc("R9", 1, 0, 12'h10C, 32'h0000_0000, 0, 0, 12'h000, 0);
    cyc("R9", 1, 0, 12'h110, 32'hBAD0_0003, 1, 0, 12'h114, 32'hBAD0_0004);
    cyc("R9", 0, 0, 12'h000, 0, 0, 1, 12'h100, 0);
    cyc("R9", 1, 0, 12'h104, 32'h0000_0001, 0, 0, 12'h000, 0);
    look("R9", 12'h104, 12'h10C);
    look("R9", 12'h100, 12'h108);

    cyc("R8", 0, 1, 12'h110, 0, 0, 1, 12'h114, 0);
    cyc("R8", 0, 1, 12'h114, 0, 0, 1, 12'h110, 0);
    look("R8", 12'h104, 12'h10C);

    look("R10", 12'h118, 12'h000);
    look("R10", 12'hFFC, 12'h10A);

    for (int i = 0; i < 4000; i++) begin
      cyc("R2", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, pick_addr(), $urandom(),
          $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, pick_addr(), $urandom());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule